// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block holds the programmable burst settings of a double-data-rate memory device and turns each column read or write command into a run of column addresses, one per data beat. A mode-register-set command writes the burst length, the burst ordering (sequential or interleaved), the read latency code and a field of operating-mode bits. Only a load that names bank zero while no burst is running is taken.

A read or write command carries a starting column. The block picks an aligned window of columns the size of the burst length. The upper column bits pick the window and the low bits give the starting offset. The block then steps through every column in that window exactly once, wrapping at the window edge. A two-state machine runs the work. In the state `IDLE` the block accepts commands. The transition `IDLE -> BURST` is taken on an accepted read or write. The state `BURST` produces beats, and the transition `BURST -> IDLE` is taken on the final beat. No other transitions exist.

Top module: `bcs_burst_seq`

## Requirements
- R1: After reset the stored burst-length code is 001 (length 2), the ordering is sequential, the illegal flag is 0, and `busy`, `beat_valid`, `beat_last` and `mrs_error` are 0.
- R2: A command with `cmd_type` 01 (mode load; 00 idle, 10 read, 11 write) and `cmd_bank` all zero, issued while idle, stores these fields: `cmd_addr[2:0]` as the length code, `cmd_addr[3]` as the ordering (1 = interleaved), `cmd_addr[6:4]` as the latency code and `cmd_addr[12:7]` as the operating-mode bits. All of them show on the mode outputs in the cycle after the command.
- R3: A mode load with any nonzero bank bit changes no mode output.
- R4: The length codes 001, 010 and 011 select lengths 2, 4 and 8. Any other code sets `mode_illegal`. While `mode_illegal` is set, read and write commands start no burst. A later legal load clears the flag.
- R5: Operating-mode bit 1 (`cmd_addr[8]`) reads 1 in the cycle after the load and 0 one cycle later. The other operating-mode bits keep their value until the next accepted load.
- R6: A bank-zero mode load that arrives while `busy` is high is rejected. The mode outputs stay unchanged and `mrs_error` is 1 for the next cycle only.
- R7: An accepted read or write raises `beat_valid` from the cycle after the command for exactly burst-length cycles. `beat_last` is high only on the final beat.
- R8: Every beat keeps the column bits at and above log2(length) from the command. In sequential order, beat n has low offset (start + n) mod length.
- R9: In interleaved order, beat n has low offset start XOR n.
- R10: Read and write commands produce the same beat count and address sequence.
- R11: `busy` is high for the whole burst and low in the cycle after the last beat. A read or write arriving during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 2 | 00 idle, 01 mode load, 10 read, 11 write |
| cmd_bank | input | BANK_W | Bank bits |
| cmd_addr | input | ADDR_W | Address bus (mode fields or start column) |
| col_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of the burst |
| busy | output | 1 | Burst in progress |
| mrs_error | output | 1 | Mode load was rejected during a burst |
| mode_bl | output | 3 | Stored burst-length code |
| mode_ilv | output | 1 | Stored ordering, 1 = interleaved |
| mode_cas | output | 3 | Stored latency code |
| mode_op | output | ADDR_W-7 | Stored operating-mode bits |
| mode_illegal | output | 1 | Stored length code is reserved |

## Verification
Bursts are run from every starting offset inside the window and at columns whose upper bits are all ones. This separates wrapping inside the window from a carry into the window-select bits. The same start is replayed in sequential and in interleaved order at lengths 4 and 8, where the two orders first differ. This shows the ordering bit is honoured. Random rounds mix reads and writes, legal and reserved length codes, and loads with nonzero banks. Directed cases place a mode load and a second read inside a running burst, so that a rejected command can be told apart from one that was taken.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_MRS   = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } state_e;

    localparam int MAX_BL_LOG2 = 3;

    // log2 of burst length for a legal code, 0 for a reserved code
    function automatic logic [1:0] bl_log2(input logic [2:0] code);
        unique case (code)
            3'b001:  return 2'd1;
            3'b010:  return 2'd2;
            3'b011:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int SC_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        bl_code_o,
    output logic              ilv_o,
    output logic [2:0]        cas_o,
    output logic [ADDR_W-8:0] op_o,
    output logic              illegal_o
);
    localparam int OP_W = ADDR_W - 7;

    logic [OP_W-1:0] op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bl_code_o <= 3'b001;
            ilv_o     <= 1'b0;
            cas_o     <= '0;
            op_q      <= '0;
            illegal_o <= 1'b0;
        end else if (load_i) begin
            bl_code_o <= addr_i[2:0];
            ilv_o     <= addr_i[3];
            cas_o     <= addr_i[6:4];
            op_q      <= addr_i[ADDR_W-1:7];
            illegal_o <= (bl_log2(addr_i[2:0]) == 2'd0);
        end else begin
            op_q[SC_BIT] <= 1'b0;
        end
    end

    assign op_o = op_q;

    // R5: the self-clearing bit survives a single cycle unless reloaded
    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        op_q[SC_BIT] && !load_i |=> !op_q[SC_BIT]);

    // R4: the flag tracks a reserved code once loaded
    a_r4_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (illegal_o == (bl_log2($past(addr_i[2:0])) == 2'd0)));
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]       start_i,
    input  logic [MAX_BL_LOG2-1:0] beat_i,
    input  logic [1:0]             len_log2_i,
    input  logic                   ilv_i,
    output logic [COL_W-1:0]       col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] offs;

    always_comb begin
        mask = '0;
        for (int i = 0; i < MAX_BL_LOG2; i++) begin
            if (i < int'(len_log2_i)) mask[i] = 1'b1;
        end
    end

    assign beat_ext = COL_W'(beat_i);

    generate
        if (COL_W > MAX_BL_LOG2) begin : g_wide
            always_comb begin
                if (ilv_i) offs = (start_i ^ beat_ext) & mask;
                else       offs = (start_i + beat_ext) & mask;
            end
        end else begin : g_narrow
            always_comb begin
                if (ilv_i) offs = (start_i ^ beat_ext[COL_W-1:0]) & mask;
                else       offs = (start_i + beat_ext[COL_W-1:0]) & mask;
            end
        end
    endgenerate

    assign col_o = (start_i & ~mask) | offs;
endmodule

// File: rtl/bcs_burst_seq.sv
module bcs_burst_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              busy,
    output logic              mrs_error,
    output logic [2:0]        mode_bl,
    output logic              mode_ilv,
    output logic [2:0]        mode_cas,
    output logic [ADDR_W-8:0] mode_op,
    output logic              mode_illegal
);
    state_e                 state_q, state_d;
    logic [COL_W-1:0]       start_q;
    logic [MAX_BL_LOG2-1:0] beat_q;
    logic [1:0]             len_log2;
    logic [MAX_BL_LOG2-1:0] last_idx;
    logic                   is_mrs, bank_zero, mrs_ok, mrs_bad, rw_go, at_last;

    assign is_mrs    = cmd_valid && (cmd_type == CMD_MRS);
    assign bank_zero = (cmd_bank == '0);
    assign mrs_ok    = is_mrs && bank_zero && (state_q == ST_IDLE);
    assign mrs_bad   = is_mrs && bank_zero && (state_q == ST_BURST);
    assign rw_go     = cmd_valid && (cmd_type[1] == 1'b1) && !mode_illegal;
    assign len_log2  = bl_log2(mode_bl);
    assign last_idx  = MAX_BL_LOG2'((1 << len_log2) - 1);
    assign at_last   = (beat_q == last_idx);

    bcs_mode_reg #(.ADDR_W(ADDR_W), .SC_BIT(1)) i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (mrs_ok),
        .addr_i    (cmd_addr),
        .bl_code_o (mode_bl),
        .ilv_o     (mode_ilv),
        .cas_o     (mode_cas),
        .op_o      (mode_op),
        .illegal_o (mode_illegal)
    );

    bcs_col_gen #(.COL_W(COL_W)) i_col (
        .start_i    (start_q),
        .beat_i     (beat_q),
        .len_log2_i (len_log2),
        .ilv_i      (mode_ilv),
        .col_o      (col_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rw_go)   state_d = ST_BURST;
            ST_BURST: if (at_last) state_d = ST_IDLE;
        endcase
    end

    // state register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            start_q   <= '0;
            beat_q    <= '0;
            mrs_error <= 1'b0;
        end else begin
            state_q   <= state_d;
            mrs_error <= mrs_bad;
            if (state_q == ST_IDLE && rw_go) begin
                start_q <= cmd_addr[COL_W-1:0];
                beat_q  <= '0;
            end else if (state_q == ST_BURST) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST: begin
                beat_valid = 1'b1;
                busy       = 1'b1;
                beat_last  = at_last;
            end
        endcase
    end

    // R7: the last flag only accompanies a beat
    a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R11: the burst ends right after its last beat
    a_r11_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> !busy);

    // R8: window-select bits hold across consecutive beats
    a_r8_same_window: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last |=>
            ((col_addr >> len_log2) == ($past(col_addr) >> $past(len_log2))));

    // R6: a load during a burst leaves the settings alone
    a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs && busy |=> $stable(mode_bl) && $stable(mode_ilv) && $stable(mode_cas));

    // R3: a load to a nonzero bank leaves the settings alone
    a_r3_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs && !bank_zero |=> $stable(mode_bl) && $stable(mode_cas) && $stable(mode_illegal));
endmodule

// File: tb/test_bcs_burst_seq.sv
`timescale 1ns/1ps
module test_bcs_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'b00;
    logic [1:0]  cmd_bank = 2'b00;
    logic [12:0] cmd_addr = '0;
    logic [9:0]  col_addr;
    logic        beat_valid, beat_last, busy, mrs_error, mode_ilv, mode_illegal;
    logic [2:0]  mode_bl, mode_cas;
    logic [5:0]  mode_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected mode state
    logic [2:0] e_bl = 3'b001;
    logic       e_ilv = 1'b0;
    logic [2:0] e_cas = 3'b000;
    logic [5:0] e_op = 6'd0;

    always #2 clk = ~clk;

    bcs_burst_seq i_bcs_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .col_addr(col_addr),
        .beat_valid(beat_valid), .beat_last(beat_last), .busy(busy),
        .mrs_error(mrs_error), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
        .mode_cas(mode_cas), .mode_op(mode_op), .mode_illegal(mode_illegal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bl_of(input logic [2:0] code);
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [9:0] exp_col(input logic [9:0] s, input int bl,
                                           input logic il, input int n);
        int base, off;
        base = int'(s) - (int'(s) % bl);
        if (il) off = (int'(s) % bl) ^ n;
        else    off = (int'(s) % bl + n) % bl;
        return 10'(base + off);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check_mode(input string req);
        check({req, " bl"}, 32'(mode_bl), 32'(e_bl));
        check({req, " ilv"}, 32'(mode_ilv), 32'(e_ilv));
        check({req, " cas"}, 32'(mode_cas), 32'(e_cas));
        check({req, " op"}, 32'(mode_op), 32'(e_op));
        check({req, " illegal"}, 32'(mode_illegal), 32'(bl_of(e_bl) == 0));
    endtask

    // mode load; checks self-clearing bit over two cycles
    task automatic mrs(input logic [1:0] bank, input logic [12:0] a);
        cmd_valid = 1; cmd_type = 2'b01; cmd_bank = bank; cmd_addr = a;
        step();
        cmd_valid = 0; cmd_bank = 0;
        if (bank == 0) begin
            e_bl = a[2:0]; e_ilv = a[3]; e_cas = a[6:4]; e_op = a[12:7];
            check_mode("R2 load");
            check("R5 sc bit high", 32'(mode_op[1]), 32'(a[8]));
        end else begin
            check_mode("R3 bank ignored");
        end
        step();
        e_op[1] = 1'b0;
        check("R5 sc bit cleared", 32'(mode_op[1]), 0);
        check_mode("R5 others kept");
    endtask

    // inject: 0 none, 1 second read at beat 1, 2 mode load at beat 0
    task automatic burst(input logic wr, input logic [9:0] s, input int inject);
        int bl;
        bl = bl_of(e_bl);
        cmd_valid = 1; cmd_type = wr ? 2'b11 : 2'b10; cmd_bank = 0; cmd_addr = 13'(s);
        step();
        cmd_valid = 0;
        if (bl == 0) begin
            check("R4 no burst when illegal", 32'(beat_valid), 0);
            check("R4 not busy when illegal", 32'(busy), 0);
            return;
        end
        for (int n = 0; n < bl; n++) begin
            cmd_valid = 0;
            check(wr ? "R10 write valid" : "R7 valid", 32'(beat_valid), 1);
            check("R11 busy", 32'(busy), 1);
            check("R7 last", 32'(beat_last), 32'(n == bl - 1));
            check(e_ilv ? "R9 col" : "R8 col", 32'(col_addr), 32'(exp_col(s, bl, e_ilv, n)));
            if (n == 1 && inject == 2) begin
                check("R6 error pulse", 32'(mrs_error), 1);
                check_mode("R6 mode kept");
            end
            if (n == 1 && inject == 1) begin
                cmd_valid = 1; cmd_type = 2'b10; cmd_addr = 13'(s ^ 10'h3ff);
            end
            if (n == 0 && inject == 2) begin
                cmd_valid = 1; cmd_type = 2'b01; cmd_addr = 13'h0fff;
            end
            step();
        end
        cmd_valid = 0;
        check("R11 idle after burst", 32'(busy), 0);
        check("R7 valid off", 32'(beat_valid), 0);
        check("R6 error once", 32'(mrs_error), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #9 rst_n = 1;
        #1;
        // R1 reset state
        check("R1 bl", 32'(mode_bl), 1);
        check("R1 ilv", 32'(mode_ilv), 0);
        check("R1 illegal", 32'(mode_illegal), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 valid", 32'(beat_valid), 0);
        check("R1 err", 32'(mrs_error), 0);
        step();
        burst(0, 10'h3ff, 0);                   // R8 top of column space, BL2
        for (int s = 0; s < 8; s++) begin       // R8 / R9 every start, BL8
            mrs(0, 13'h0003 | 13'((s & 1) << 3));
            burst(s[1], 10'(10'h3f8 | s), 0);
        end
        mrs(0, 13'h0012);                        // BL4 seq, cas 1
        burst(0, 10'h2b7, 0);
        mrs(0, 13'h011a);                        // BL4 interleaved, op bit 1 set
        burst(1, 10'h2b7, 0);
        burst(0, 10'h105, 1);                    // R11 second read ignored
        burst(1, 10'h0c6, 2);                    // R6 load rejected
        mrs(2'b01, 13'h0000);                    // R3
        mrs(0, 13'h0004);                        // R4 reserved
        burst(0, 10'h011, 0);
        mrs(0, 13'h0000);                        // R4 reserved 000
        burst(1, 10'h011, 0);
        mrs(0, 13'h0002);                        // R4 cleared by legal load
        burst(0, 10'h011, 0);
        for (int r = 0; r < 300; r++) begin
            logic [12:0] a;
            logic [1:0] b;
            a = 13'($urandom);
            if ($urandom % 4 != 0) a[2:0] = 3'(1 + $urandom % 3);
            b = ($urandom % 5 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
            mrs(b, a);
            burst(1'($urandom), 10'($urandom), int'($urandom % 3));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule